// File: doc/BRIEF.md
# Configurable SPI Serial Shift Engine

This block is the bit-level core of an SPI master. It takes one word at a time through a valid/ready handshake. It shifts the word out on `mosi` and samples `miso` on the opposite clock edge, using the serial clock that its own divider produces. When the last bit has been exchanged, it returns the received word with a one-cycle strobe and raises a flag to show that its shift register is empty again.

Four control inputs set the word length (1 to 16 bits), the idle level of the serial clock, the capture phase and the bit order. A divider input sets the serial clock half-period in input-clock cycles. A loopback input feeds the engine's own transmit line back into its receiver, which allows a self-test without an external device. Configuration is captured when a word is accepted and stays fixed until that word completes. Chip select, buffering and register access belong to the surrounding logic.

Top module: `spi_shift_engine`

## Requirements
- R1: While no word is in flight, `tx_ready` and `shift_empty` are 1, `mosi` is 0 and `sclk` rests at the `cfg_cpol` level.
- R2: Each serial clock half-period lasts exactly N input clocks, where N is the value of `cfg_div`, except that `cfg_div` = 0 gives N = 65536. The first `sclk` edge comes N clocks after the accepting clock edge. Values 1 to 6 are not supported.
- R3: `cfg_width` holds the bit count minus one, so a word has B = `cfg_width`+1 bits (0xF gives 16 bits, 0x7 gives 8 bits) and produces exactly 2·B `sclk` edges.
- R4: With `cfg_msb_first` = 1, bit B−1 of the word is sent first and the first bit received lands in bit B−1. With `cfg_msb_first` = 0, bit 0 goes first on both lines.
- R5: With `cfg_cpha` = 0, the first bit is on `mosi` before the first edge, `miso` is sampled on odd-numbered edges and `mosi` changes on even-numbered edges. With `cfg_cpha` = 1, `mosi` changes on odd-numbered edges and `miso` is sampled on even-numbered edges. Edges are numbered 1..2B from the start of the word.
- R6: `cfg_cpol` sets the idle level of `sclk`, and `sclk` is back at that level after the last edge of a word.
- R7: With `cfg_loop` = 1, the received word equals the transmitted word masked to B bits, and `miso` has no effect.
- R8: The received word is right-aligned in `rx_data`, and bits B and above read as 0 whatever was offered in the upper bits of `tx_data` or on `miso`.
- R9: `shift_empty`, `tx_ready` and a one-cycle `rx_valid` pulse appear one input clock after the clock edge that produces the final `sclk` edge. A `tx_valid` presented while a word is in flight starts nothing and does not disturb the word being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Half-period in input clocks (0 = 65536) |
| cfg_width | input | 4 | Bits per word minus one |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_msb_first | input | 1 | 1: most significant bit first, 0: least significant first |
| cfg_loop | input | 1 | Route transmit line to receiver internally |
| tx_data | input | MAX_W | Word to send |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Engine can accept a word |
| rx_data | output | MAX_W | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when rx_data is new |
| shift_empty | output | 1 | Shift register empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that `cfg_div` is never 1 to 6 and that the configuration inputs do not change while the engine is idle and a word is about to be accepted. The assertion on the upper received bits relies on the captured width, so it remains valid if the configuration changes during a word. The stimulus uses only divider values of 7 and above, including the encoded value 0, and it sets every configuration input before it raises `tx_valid`. A behavioural slave model drives `miso` only after a shift edge, so the line is always stable at the sample edge the engine uses.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } eng_state_e;

  // Divider field to half-period length; zero stands for the wrapped full range
  function automatic int unsigned half_cycles(input int unsigned field, input int unsigned field_w);
    return (field == 0) ? (32'd1 << field_w) : field;
  endfunction

  // Width field holds count minus one
  function automatic int unsigned word_bits(input int unsigned field);
    return field + 1;
  endfunction

  // Position in the word of the j-th bit on the wire
  function automatic int unsigned bit_slot(input int unsigned j, input int unsigned len,
                                           input logic msb_first);
    return msb_first ? (len - 1 - j) : j;
  endfunction

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q == '0)  cnt_q <= reload;
    else                           cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (cnt_q <= reload)); // R2

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_eng_pkg::*;
#(
  parameter int MAX_W  = 16,
  parameter int LEN_W  = 5,
  parameter int EDGE_W = 6,
  localparam int SLOT_W = $clog2(MAX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAX_W-1:0]  load_word,
  input  logic [LEN_W-1:0]  cur_len,
  input  logic              cur_cpha,
  input  logic              cur_msb,
  input  logic              cur_loop,
  input  logic              step,
  input  logic [EDGE_W-1:0] edge_num,
  input  logic              clear_out,
  input  logic              miso,
  output logic              mosi,
  output logic [MAX_W-1:0]  rx_word,
  output logic              drive_evt,
  output logic              sample_evt
);
  logic [MAX_W-1:0]  tx_q, rx_q;
  logic              mosi_q, rx_in, odd_edge;
  logic [EDGE_W-1:0] half_idx, samp_idx;
  logic [SLOT_W-1:0] drive_slot, samp_slot, first_slot;

  assign odd_edge = edge_num[0];
  assign half_idx = edge_num >> 1;
  assign samp_idx = cur_cpha ? half_idx - 1'b1 : half_idx;

  assign drive_evt  = step && (cur_cpha ? odd_edge
                                        : (!odd_edge && (32'(half_idx) < 32'(cur_len))));
  assign sample_evt = step && (cur_cpha ? !odd_edge : odd_edge);

  assign drive_slot = SLOT_W'(bit_slot(32'(half_idx), 32'(cur_len), cur_msb));
  assign samp_slot  = SLOT_W'(bit_slot(32'(samp_idx), 32'(cur_len), cur_msb));
  assign first_slot = SLOT_W'(bit_slot(0, 32'(cur_len), cur_msb));

  assign rx_in   = cur_loop ? mosi_q : miso;
  assign mosi    = mosi_q;
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q   <= load_word;
      rx_q   <= '0;
      mosi_q <= cur_cpha ? 1'b0 : load_word[first_slot];
    end else if (clear_out) begin
      mosi_q <= 1'b0;
    end else begin
      if (drive_evt)  mosi_q <= tx_q[drive_slot];
      if (sample_evt) rx_q[samp_slot] <= rx_in;
    end
  end

  AST_MOSI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear_out && !drive_evt) |=> $stable(mosi)); // R5

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MAX_W = 16,
  localparam int WID_W  = $clog2(MAX_W),
  localparam int LEN_W  = $clog2(MAX_W + 1),
  localparam int EDGE_W = $clog2(2 * MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_msb_first,
  input  logic             cfg_loop,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_valid,
  output logic             shift_empty,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_e        state_q;
  logic [DIV_W-1:0]  div_q;
  logic [WID_W-1:0]  width_q;
  logic              cpol_q, cpha_q, msb_q, loop_q;
  logic              sclk_q, rx_valid_q;
  logic [EDGE_W-1:0] edge_cnt_q;

  logic              idle, shifting, accept, tick, last_edge;
  logic              drive_evt, sample_evt;
  logic [DIV_W-1:0]  div_sel, reload;
  logic [LEN_W-1:0]  cur_len;
  logic [EDGE_W-1:0] edge_num, total_edges;
  logic              cur_cpha, cur_msb, cur_loop;

  assign idle     = (state_q == ENG_IDLE);
  assign shifting = (state_q == ENG_SHIFT);
  assign accept   = idle && tx_valid;

  // Live configuration while idle, captured copy once a word is in flight
  assign div_sel  = idle ? cfg_div : div_q;
  assign cur_len  = LEN_W'(word_bits(32'(idle ? cfg_width : width_q)));
  assign cur_cpha = idle ? cfg_cpha : cpha_q;
  assign cur_msb  = idle ? cfg_msb_first : msb_q;
  assign cur_loop = idle ? cfg_loop : loop_q;
  assign reload   = DIV_W'(half_cycles(32'(div_sel), DIV_W) - 1);

  assign edge_num    = edge_cnt_q + 1'b1;
  assign total_edges = EDGE_W'(cur_len) << 1;
  assign last_edge   = shifting && tick && (edge_num == total_edges);

  spi_baud_tick #(.CNT_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (shifting),
    .reload (reload),
    .tick   (tick)
  );

  spi_shift_path #(.MAX_W(MAX_W), .LEN_W(LEN_W), .EDGE_W(EDGE_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_word  (tx_data),
    .cur_len    (cur_len),
    .cur_cpha   (cur_cpha),
    .cur_msb    (cur_msb),
    .cur_loop   (cur_loop),
    .step       (shifting && tick),
    .edge_num   (edge_num),
    .clear_out  (state_q == ENG_TAIL),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_data),
    .drive_evt  (drive_evt),
    .sample_evt (sample_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      div_q      <= '0;
      width_q    <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      msb_q      <= 1'b0;
      loop_q     <= 1'b0;
      sclk_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      edge_cnt_q <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ENG_IDLE: begin
          sclk_q <= cfg_cpol;
          if (accept) begin
            div_q      <= cfg_div;
            width_q    <= cfg_width;
            cpol_q     <= cfg_cpol;
            cpha_q     <= cfg_cpha;
            msb_q      <= cfg_msb_first;
            loop_q     <= cfg_loop;
            edge_cnt_q <= '0;
            state_q    <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            sclk_q     <= ~sclk_q;
            edge_cnt_q <= edge_num;
            if (last_edge) state_q <= ENG_TAIL;
          end
        end
        ENG_TAIL: begin
          sclk_q     <= cfg_cpol;
          rx_valid_q <= 1'b1;
          state_q    <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign sclk        = sclk_q;
  assign tx_ready    = idle;
  assign shift_empty = idle;
  assign rx_valid    = rx_valid_q;

  AST_IDLE_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !mosi); // R1
  AST_TICK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && tick) |=> (sclk != $past(sclk))); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !tick) |=> $stable(sclk)); // R2
  AST_LAST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> (sclk == cpol_q)); // R6
  AST_EMPTY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> ##1 (shift_empty && rx_valid)); // R9
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> word_bits(32'(width_q))) == '0)); // R8
  AST_NO_DUAL_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_evt && sample_evt)); // R5

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd7;
  logic [3:0]  cfg_width = 4'd7;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_msb_first = 1'b1, cfg_loop = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, shift_empty, sclk, mosi;
  logic [15:0] rx_data;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_width(cfg_width),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_msb_first(cfg_msb_first),
    .cfg_loop(cfg_loop), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .shift_empty(shift_empty),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int wire_pos(input int j, input int b, input bit msb);
    return msb ? (b - 1 - j) : j;
  endfunction

  // Generic transfer with a behavioural slave; poke != 0 offers a second word mid-flight
  task automatic run_xfer(input int width, input bit cpol, input bit cpha, input bit msb,
                          input bit loopb, input int div, input logic [15:0] txw,
                          input logic [15:0] slw, input bit poke, input string tag);
    int b, n, e, cyc, gap_bad, mosi_bad, limit;
    bit done, prev;
    logic [15:0] exp_rx, mask;
    b = width + 1;
    n = (div == 0) ? 65536 : div;
    mask = 16'((32'd1 << b) - 1);
    exp_rx = loopb ? (txw & mask) : (slw & mask);
    e = 0; cyc = 1; gap_bad = 0; mosi_bad = 0; done = 0;
    limit = 2*b*n + 20;
    @(negedge clk);
    cfg_width = 4'(width); cfg_cpol = cpol; cfg_cpha = cpha; cfg_msb_first = msb;
    cfg_loop = loopb; cfg_div = 16'(div);
    miso = loopb ? ~slw[wire_pos(0, b, msb)] : slw[wire_pos(0, b, msb)];
    @(negedge clk);
    tx_data = txw; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = 16'hFFFF;
    prev = cpol;
    while (!done && cyc < limit) begin
      if (sclk != prev) begin
        e++;
        prev = sclk;
        if (cyc != e*n + 1) gap_bad++;
        if ((cpha == 0 && e[0] == 1) || (cpha == 1 && e[0] == 0)) begin
          int j = cpha ? (e/2 - 1) : (e/2);
          if (mosi !== txw[wire_pos(j, b, msb)]) mosi_bad++;
        end else begin
          int j = cpha ? (e/2) : (e/2);
          if (j < b) miso = loopb ? ~slw[wire_pos(j, b, msb)] : slw[wire_pos(j, b, msb)];
        end
        if (poke && e == 3) begin
          tx_data = 16'h5A5A; tx_valid = 1'b1;
          check(tx_ready == 1'b0, {"R9 busy refuses ", tag}, tx_ready, 0);
        end
        if (poke && e == 2*b - 1) tx_valid = 1'b0;
      end
      if (shift_empty) done = 1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(done && cyc == 2*b*n + 2, {"R9 empty latency ", tag}, cyc, 2*b*n + 2);
    check(gap_bad == 0, {"R2 half period ", tag}, gap_bad, 0);
    check(e == 2*b, {"R3 edge count ", tag}, e, 2*b);
    check(mosi_bad == 0, {"R4 R5 mosi order ", tag}, mosi_bad, 0);
    check(rx_valid == 1'b1 && rx_data == exp_rx, {"R7 R8 rx word ", tag}, rx_data, exp_rx);
    check(sclk == cpol && mosi == 1'b0 && tx_ready, {"R6 R1 back idle ", tag}, {sclk, mosi}, {cpol, 1'b0});
    @(negedge clk);
    check(rx_valid == 1'b0, {"R9 strobe one cycle ", tag}, rx_valid, 0);
  endtask

  task automatic t_reset;
    check(tx_ready && shift_empty && !mosi && !sclk && !rx_valid, "R1 reset idle",
          {tx_ready, shift_empty, mosi, sclk, rx_valid}, 5'b11000);
    cfg_cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1 && !mosi, "R6 idle level follows polarity", sclk, 1);
    cfg_cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R6 idle level low", sclk, 0);
  endtask

  task automatic t_mode0_msb8;  run_xfer(7, 0, 0, 1, 0, 7, 16'h00A5, 16'h003C, 0, "m0 msb 8b"); endtask
  task automatic t_mode3_lsb16; run_xfer(15, 1, 1, 0, 0, 9, 16'h1234, 16'hBEEF, 0, "m3 lsb 16b"); endtask
  task automatic t_mode1_w5;    run_xfer(4, 0, 1, 1, 0, 8, 16'hFFF5, 16'hFFEA, 0, "m1 5b upper"); endtask
  task automatic t_mode2_loop;  run_xfer(11, 1, 0, 0, 1, 7, 16'hF9C3, 16'h0000, 0, "m2 loop 12b"); endtask
  task automatic t_busy_poke;   run_xfer(7, 0, 0, 1, 0, 7, 16'h0081, 16'h00C3, 1, "busy poke"); endtask

  task automatic t_no_restart;
    repeat (3) @(negedge clk);
    check(tx_ready && sclk == cfg_cpol, "R9 offered word while busy not started", tx_ready, 1);
  endtask

  task automatic t_div_zero;    run_xfer(0, 0, 0, 1, 0, 0, 16'h0001, 16'h0000, 0, "div zero 1b"); endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x%0h expected=0x%0h", WD_CYCLES, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_msb8();
    t_mode3_lsb16();
    t_mode1_w5();
    t_mode2_loop();
    t_busy_poke();
    t_no_restart();
    t_div_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule